// File: doc/BRIEF.md
# Per-Pin Addressed GPIO Peripheral

This peripheral hangs off a small processor's I/O bus, which offers a read strobe, a write strobe, a 16-bit address and 32-bit data. It controls two banks of bidirectional pins. Every pin has one address for its data bit and a second address for its direction bit. Software therefore sets, clears or samples one pin per access instead of doing a read-modify-write on a whole port word.

The upper address byte is the page. Page 0x00 is bank A data and page 0x01 is bank A direction. Page 0x02 is bank B data and page 0x03 is bank B direction. In these four pages the lower byte is the pin index. Page 0x04 holds two registers: a read-only button word at 0x0400 and a write-only LED latch at 0x0404.

The block drives an output value and an output enable for each pin. The pad logic outside the block applies the tri-state. Pin inputs and button inputs are synchronized with two flops before software can read them. Read data is registered.

Top module: `pinmap_gpio`

## Requirements
- R1: After a synchronous reset every direction bit, every output-value bit, the LED latch and the read data register are 0, so all output enables are low.
- R2: A write to 0x00NN (bank A) or 0x02NN (bank B) loads bit 0 of the write data into the output value of pin NN. Write data bits 31:1 are ignored, and no other pin changes.
- R3: A write to 0x01NN (bank A) or 0x03NN (bank B) loads bit 0 of the write data into the direction bit of pin NN, where 1 means output. The pin's output enable equals its direction bit, and no other pin changes.
- R4: A read of 0x00NN or 0x02NN returns the synchronized level of pin NN in bit 0, with bits 31:1 zero. The value appears on the read data port in the cycle after the read strobe and holds until the next read.
- R5: A read of 0x01NN or 0x03NN returns the stored direction bit of pin NN in bit 0, with bits 31:1 zero.
- R6: Each bank has pins 0 to 27. A data or direction access with a low address byte of 28 to 255 changes nothing when written and reads as zero.
- R7: A read of 0x0400 returns the synchronized buttons in bits 5:0, ordered from bit 0 upward as F1, F2, UP, DOWN, LEFT, RIGHT, with bits 31:6 zero.
- R8: A write to 0x0404 latches write data bits 7:0 onto the LED outputs, with LED n taken from bit n. Bits 31:8 are ignored, and a read of 0x0404 returns zero.
- R9: A read of any other address returns zero. A write to any other address changes no pin, direction or LED state.
- R10: An input change is captured by the first read strobe sampled on the third rising clock edge after the change. A strobe on the first or the second edge still returns the old level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_addr | input | 16 | Access address |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Registered read data |
| pa_in | input | 28 | Bank A pad levels |
| pa_out | output | 28 | Bank A output values |
| pa_oe | output | 28 | Bank A output enables |
| pb_in | input | 28 | Bank B pad levels |
| pb_out | output | 28 | Bank B output values |
| pb_oe | output | 28 | Bank B output enables |
| btn_in | input | 6 | Button levels |
| led_out | output | 8 | LED drive |

## Verification
Every pin index of both banks is swept for data and direction writes. Each write uses a word with bit 0 clear and upper bits set, which shows whether only bit 0 is used and whether neighbouring pins stay put. Reads run over a pad model that loops each pin's output back when it is enabled and supplies an external pattern when it is not, which separates the output enable from the data path. All out-of-range indices and several unmapped pages are probed. All 64 button codes are read back. A held read strobe measures the exact synchronizer latency.

// File: rtl/pinmap_pkg.sv
package pinmap_pkg;
  localparam logic [7:0] PG_A_DAT = 8'h00;
  localparam logic [7:0] PG_A_DIR = 8'h01;
  localparam logic [7:0] PG_B_DAT = 8'h02;
  localparam logic [7:0] PG_B_DIR = 8'h03;
  localparam logic [7:0] PG_MISC  = 8'h04;
  localparam logic [7:0] LO_BTN   = 8'h00;
  localparam logic [7:0] LO_LED   = 8'h04;

  typedef struct packed {
    logic a_dat;
    logic a_dir;
    logic b_dat;
    logic b_dir;
    logic btn;
    logic led;
  } sel_t;

  function automatic sel_t decode(input logic [7:0] hi, input logic [7:0] lo);
    sel_t s;
    s.a_dat = (hi == PG_A_DAT);
    s.a_dir = (hi == PG_A_DIR);
    s.b_dat = (hi == PG_B_DAT);
    s.b_dir = (hi == PG_B_DIR);
    s.btn   = (hi == PG_MISC) && (lo == LO_BTN);
    s.led   = (hi == PG_MISC) && (lo == LO_LED);
    return s;
  endfunction
endpackage

// File: rtl/pinmap_sync.sv
module pinmap_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pinmap_bank.sv
module pinmap_bank #(
  parameter int PINS = 28
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            dat_we,
  input  logic            dir_we,
  input  logic [7:0]      idx,
  input  logic            wbit,
  input  logic [PINS-1:0] lvl_s,
  output logic [PINS-1:0] out_q,
  output logic [PINS-1:0] dir_q,
  output logic            rd_lvl,
  output logic            rd_dir
);
  localparam int         PIDX_W = (PINS > 1) ? $clog2(PINS) : 1;
  localparam logic [7:0] LIMIT  = 8'(PINS);

  logic              in_range;
  logic [PIDX_W-1:0] pidx;

  assign in_range = (idx < LIMIT);
  assign pidx     = idx[PIDX_W-1:0];

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    localparam logic [7:0] MY_IDX = 8'(i);
    always_ff @(posedge clk) begin
      if (rst) begin
        out_q[i] <= 1'b0;
        dir_q[i] <= 1'b0;
      end else begin
        if (dat_we && idx == MY_IDX) out_q[i] <= wbit;
        if (dir_we && idx == MY_IDX) dir_q[i] <= wbit;
      end
    end
  end

  assign rd_lvl = in_range ? lvl_s[pidx] : 1'b0;
  assign rd_dir = in_range ? dir_q[pidx] : 1'b0;
endmodule

// File: rtl/pinmap_gpio.sv
module pinmap_gpio
  import pinmap_pkg::*;
#(
  parameter int PINS   = 28,
  parameter int BTNS   = 6,
  parameter int LEDS   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [15:0]       io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic [PINS-1:0]   pa_in,
  output logic [PINS-1:0]   pa_out,
  output logic [PINS-1:0]   pa_oe,
  input  logic [PINS-1:0]   pb_in,
  output logic [PINS-1:0]   pb_out,
  output logic [PINS-1:0]   pb_oe,
  input  logic [BTNS-1:0]   btn_in,
  output logic [LEDS-1:0]   led_out
);
  logic [7:0]      hi, lo;
  sel_t            sel;
  logic [PINS-1:0] pa_s, pb_s, pa_dir, pb_dir;
  logic [BTNS-1:0] btn_s;
  logic            a_lvl, a_dir, b_lvl, b_dir;
  logic [DATA_W-1:0] rd_val;

  assign hi  = io_addr[15:8];
  assign lo  = io_addr[7:0];
  assign sel = decode(hi, lo);

  pinmap_sync #(.W(PINS)) u_sync_a   (.clk(clk), .rst(rst), .d(pa_in),  .q(pa_s));
  pinmap_sync #(.W(PINS)) u_sync_b   (.clk(clk), .rst(rst), .d(pb_in),  .q(pb_s));
  pinmap_sync #(.W(BTNS)) u_sync_btn (.clk(clk), .rst(rst), .d(btn_in), .q(btn_s));

  pinmap_bank #(.PINS(PINS)) u_bank_a (
    .clk(clk), .rst(rst),
    .dat_we(io_wr && sel.a_dat), .dir_we(io_wr && sel.a_dir),
    .idx(lo), .wbit(io_wdata[0]), .lvl_s(pa_s),
    .out_q(pa_out), .dir_q(pa_dir), .rd_lvl(a_lvl), .rd_dir(a_dir)
  );

  pinmap_bank #(.PINS(PINS)) u_bank_b (
    .clk(clk), .rst(rst),
    .dat_we(io_wr && sel.b_dat), .dir_we(io_wr && sel.b_dir),
    .idx(lo), .wbit(io_wdata[0]), .lvl_s(pb_s),
    .out_q(pb_out), .dir_q(pb_dir), .rd_lvl(b_lvl), .rd_dir(b_dir)
  );

  assign pa_oe = pa_dir;
  assign pb_oe = pb_dir;

  always_ff @(posedge clk) begin
    if (rst) led_out <= '0;
    else if (io_wr && sel.led) led_out <= io_wdata[LEDS-1:0];
  end

  always_comb begin
    rd_val = '0;
    if (sel.a_dat) rd_val[0] = a_lvl;
    if (sel.a_dir) rd_val[0] = a_dir;
    if (sel.b_dat) rd_val[0] = b_lvl;
    if (sel.b_dir) rd_val[0] = b_dir;
    if (sel.btn)   rd_val[BTNS-1:0] = btn_s;
  end

  always_ff @(posedge clk) begin
    if (rst) io_rdata <= '0;
    else if (io_rd) io_rdata <= rd_val;
  end
endmodule

// File: rtl/pinmap_checker.sv
module pinmap_checker #(
  parameter int PINS   = 28,
  parameter int LEDS   = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              io_wr,
  input logic              io_rd,
  input logic [15:0]       io_addr,
  input logic [DATA_W-1:0] io_rdata,
  input logic [PINS-1:0]   pa_out,
  input logic [PINS-1:0]   pa_oe,
  input logic [PINS-1:0]   pb_out,
  input logic [PINS-1:0]   pb_oe,
  input logic [LEDS-1:0]   led_out
);
  localparam logic [7:0] LIMIT = 8'(PINS);

  p_cleared_r1: assert property (@(posedge clk)
    rst |=> (pa_oe == '0 && pb_oe == '0 && led_out == '0 && io_rdata == '0));

  p_a_out_only_on_write_r2: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_addr[15:8] == 8'h00) |=> $stable(pa_out));

  p_b_out_only_on_write_r2: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_addr[15:8] == 8'h02) |=> $stable(pb_out));

  p_oe_only_on_write_r3: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && (io_addr[15:8] == 8'h01 || io_addr[15:8] == 8'h03))
      |=> ($stable(pa_oe) && $stable(pb_oe)));

  p_single_pin_r3: assert property (@(posedge clk) disable iff (rst)
    io_wr |=> ($countones(pa_oe ^ $past(pa_oe)) <= 1 && $countones(pb_out ^ $past(pb_out)) <= 1));

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> $stable(io_rdata));

  p_oob_write_r6: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr[15:8] <= 8'h03 && io_addr[7:0] >= LIMIT)
      |=> ($stable(pa_out) && $stable(pb_out) && $stable(pa_oe) && $stable(pb_oe)));

  p_btn_upper_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == 16'h0400) |=> (io_rdata[DATA_W-1:6] == '0));

  p_led_only_on_write_r8: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_addr == 16'h0404) |=> $stable(led_out));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr[15:8] > 8'h04) |=> (io_rdata == '0));
endmodule

bind pinmap_gpio pinmap_checker #(.PINS(PINS), .LEDS(LEDS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
  .io_rdata(io_rdata), .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out),
  .pb_oe(pb_oe), .led_out(led_out)
);

// File: tb/pinmap_gpio_bench.sv
`timescale 1ns/1ps
module pinmap_gpio_bench;
  localparam int P = 28;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic [P-1:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe;
  logic [P-1:0] ext_a = '0, ext_b = '0;
  logic [5:0]  btn_in = '0;
  logic [7:0]  led_out;

  int checks = 0;
  int errors = 0;
  logic [P-1:0] m_out [2];
  logic [P-1:0] m_dir [2];

  always #4 clk = ~clk;

  assign pa_in = (pa_oe & pa_out) | (~pa_oe & ext_a);
  assign pb_in = (pb_oe & pb_out) | (~pb_oe & ext_b);

  pinmap_gpio u_pinmap_gpio (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .btn_in(btn_in), .led_out(led_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  function automatic logic [P-1:0] outs(input int b);
    return (b == 0) ? pa_out : pb_out;
  endfunction

  function automatic logic [P-1:0] oes(input int b);
    return (b == 0) ? pa_oe : pb_oe;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    m_out[0] = '0; m_out[1] = '0; m_dir[0] = '0; m_dir[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 oe", {4'b0, pa_oe | pb_oe}, 32'h0);
    chk("R1 out", {4'b0, pa_out | pb_out}, 32'h0);
    chk("R1 led", {24'b0, led_out}, 32'h0);
    chk("R1 rdata", io_rdata, 32'h0);

    // R2: per-pin data writes, bit 0 only
    for (int b = 0; b < 2; b++) begin
      for (int p = 0; p < P; p++) begin
        wr({7'b0, b[0], 1'b0, 8'(p)}, 32'hFFFF_FFFE);
        chk("R2 upper bits ignored", {4'b0, outs(b)}, {4'b0, m_out[b]});
        wr({7'b0, b[0], 1'b0, 8'(p)}, 32'h0000_0001);
        m_out[b][p] = 1'b1;
        chk("R2 set pin", {4'b0, outs(b)}, {4'b0, m_out[b]});
      end
      for (int p = 0; p < P; p++) begin
        if (p % 3 != 0) begin
          wr({7'b0, b[0], 1'b0, 8'(p)}, 32'h8000_0000);
          m_out[b][p] = 1'b0;
          chk("R2 clear pin", {4'b0, outs(b)}, {4'b0, m_out[b]});
        end
      end
    end

    // R3: direction writes, R5: direction reads
    for (int b = 0; b < 2; b++) begin
      for (int p = 0; p < P; p++) begin
        if ((p + b) % 2 == 0) begin
          wr({7'b0, b[0], 1'b1, 8'(p)}, 32'hFFFF_FF01);
          m_dir[b][p] = 1'b1;
        end else begin
          wr({7'b0, b[0], 1'b1, 8'(p)}, 32'h0000_0000);
        end
        chk("R3 oe", {4'b0, oes(b)}, {4'b0, m_dir[b]});
      end
      for (int p = 0; p < P; p++) begin
        rd({7'b0, b[0], 1'b1, 8'(p)}, r);
        chk("R5 dir read", r, {31'b0, m_dir[b][p]});
      end
    end

    // R4: level reads through pad loopback
    ext_a = 28'h5A5_3C96;
    ext_b = 28'hA3C_69E1;
    repeat (3) @(negedge clk);
    for (int b = 0; b < 2; b++) begin
      for (int p = 0; p < P; p++) begin
        logic [P-1:0] e;
        e = (b == 0) ? ext_a : ext_b;
        rd({7'b0, b[0], 1'b0, 8'(p)}, r);
        chk("R4 level read", r,
            {31'b0, (m_dir[b][p] & m_out[b][p]) | (~m_dir[b][p] & e[p])});
      end
    end

    // R6: out-of-range pin indices
    for (int pg = 0; pg < 4; pg++) begin
      for (int p = P; p < 256; p++) begin
        wr({8'(pg), 8'(p)}, 32'hFFFF_FFFF);
        if (p == P || p == 255) begin
          rd({8'(pg), 8'(p)}, r);
          chk("R6 oob read", r, 32'h0);
        end
      end
      chk("R6 oob write A out", {4'b0, pa_out}, {4'b0, m_out[0]});
      chk("R6 oob write B out", {4'b0, pb_out}, {4'b0, m_out[1]});
      chk("R6 oob write A oe", {4'b0, pa_oe}, {4'b0, m_dir[0]});
      chk("R6 oob write B oe", {4'b0, pb_oe}, {4'b0, m_dir[1]});
    end

    // R7: all button codes
    for (int v = 0; v < 64; v++) begin
      btn_in = 6'(v);
      repeat (3) @(negedge clk);
      rd(16'h0400, r);
      chk("R7 buttons", r, {26'b0, 6'(v)});
    end

    // R8: LED latch
    wr(16'h0404, 32'hABCD_EF5A);
    chk("R8 led low byte", {24'b0, led_out}, 32'h5A);
    wr(16'h0404, 32'h1234_56A5);
    chk("R8 led second value", {24'b0, led_out}, 32'hA5);
    rd(16'h0404, r);
    chk("R8 led write-only", r, 32'h0);

    // R9: unmapped addresses
    wr(16'h0401, 32'hFFFF_FFFF);
    wr(16'h0500, 32'hFFFF_FFFF);
    wr(16'hFF04, 32'hFFFF_FFFF);
    chk("R9 led untouched", {24'b0, led_out}, 32'hA5);
    chk("R9 A out untouched", {4'b0, pa_out}, {4'b0, m_out[0]});
    chk("R9 B oe untouched", {4'b0, pb_oe}, {4'b0, m_dir[1]});
    rd(16'h0401, r); chk("R9 read 0x0401", r, 32'h0);
    rd(16'h0500, r); chk("R9 read 0x0500", r, 32'h0);
    rd(16'hFF00, r); chk("R9 read 0xFF00", r, 32'h0);

    // R10: synchronizer latency on bank A pin 3 (input: odd pin in bank A)
    ext_a[3] = 1'b0;
    repeat (3) @(negedge clk);
    io_rd = 1'b1; io_addr = 16'h0003;
    ext_a[3] = 1'b1;
    @(negedge clk);
    chk("R10 edge1 old", io_rdata, 32'h0);
    @(negedge clk);
    chk("R10 edge2 old", io_rdata, 32'h0);
    @(negedge clk);
    chk("R10 edge3 new", io_rdata, 32'h1);
    io_rd = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule